// File: doc/BRIEF.md
# Subframe Timing Signal Generator

This block keeps a single chip counter that spans one physical subframe of 2880 chip periods. A chip-rate enable, which pulses at eight times the bit rate, advances the counter. From the counter position the block derives one-cycle strobes that mark bit, byte and subframe starts. It also derives two warning strobes that fire one bit time (eight chips) ahead of each byte start and each subframe start, and a level signal that covers the gap between the subframe warning and the subframe start.

Transmit and receive logic share the counter. The mode flag does not reset or disturb it, so strobes keep the same relative timing in both directions. Downstream logic uses the warning strobes to prepare the next byte or subframe. It can use the level signal to line up an external controller with subframe starts.

Top module: `subframe_timer`

## Requirements
- R1: On a clock edge where the chip enable is high, the chip count advances by one and wraps from 2879 to 0. When the enable is low, the count holds.
- R2: The bit strobe is high exactly on enabled cycles whose count is a multiple of 8 (0, 8, …, 2872).
- R3: The byte strobe is high exactly on enabled cycles whose count is a multiple of 64 (0, 64, …, 2816). There are 45 byte strobes per subframe.
- R4: The subframe strobe is high exactly on enabled cycles whose count is 0.
- R5: The byte warning strobe is high exactly on enabled cycles whose count modulo 64 equals 56. This includes count 2872.
- R6: The subframe warning strobe is high exactly on enabled cycles whose count is 2872.
- R7: The pre-slot level becomes 1 after the edge on which the subframe warning strobe was high. It becomes 0 after the edge on which the subframe strobe was high, and otherwise holds.
- R8: With the chip enable low, all five strobes are 0.
- R9: Changing the transmit/receive mode flag has no effect on the count, the strobes or the pre-slot level.
- R10: A synchronous reset sets the count to 0 and the pre-slot level to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip-rate enable, one pulse per chip period |
| tx_mode | input | 1 | Transmit (1) / receive (0) mode flag |
| chip_count | output | 12 | Current chip position in the subframe |
| bit_stb | output | 1 | Bit start strobe |
| byte_stb | output | 1 | Byte start strobe |
| frame_stb | output | 1 | Subframe start strobe |
| pre_byte_stb | output | 1 | Warning strobe eight chips before a byte start |
| pre_frame_stb | output | 1 | Warning strobe eight chips before a subframe start |
| pre_slot | output | 1 | High from the subframe warning to the subframe start |

## Verification
The assertions check on every cycle that the count steps, wraps and holds correctly. They also check that each strobe appears only at a count that fits its position modulo the bit or byte length, that no strobe appears without the enable, and that the pre-slot level rises and falls only after the matching strobes. Some behaviours can only be shown by the bench's scenarios: a strobe appearing at every position where it is due, exactly 45 byte strobes per subframe, mode changes leaving the timing untouched, and a reset in mid-subframe restarting cleanly. The bench covers these by running a free-standing model across sparse and full enable patterns.

// File: rtl/subframe_timer.sv
module subframe_timer #(
  parameter int CHIPS_PER_BIT   = 8,
  parameter int BITS_PER_BYTE   = 8,
  parameter int BYTES_PER_FRAME = 45,
  parameter int LEAD_BITS       = 1,
  localparam int FRAME_CHIPS = CHIPS_PER_BIT * BITS_PER_BYTE * BYTES_PER_FRAME,
  localparam int CW  = $clog2(FRAME_CHIPS),
  localparam int PW  = (CHIPS_PER_BIT   > 1) ? $clog2(CHIPS_PER_BIT)   : 1,
  localparam int BW  = (BITS_PER_BYTE   > 1) ? $clog2(BITS_PER_BYTE)   : 1,
  localparam int YW  = (BYTES_PER_FRAME > 1) ? $clog2(BYTES_PER_FRAME) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en,
  input  logic          tx_mode,
  output logic [CW-1:0] chip_count,
  output logic          bit_stb,
  output logic          byte_stb,
  output logic          frame_stb,
  output logic          pre_byte_stb,
  output logic          pre_frame_stb,
  output logic          pre_slot
);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] chip_ph_q;
  logic [BW-1:0] bit_ph_q;
  logic [YW-1:0] byte_ix_q;
  logic          slot_q;

  logic chip_last, bit_last, byte_last, frame_last;
  logic unused_mode;

  assign unused_mode = tx_mode;

  assign chip_last  = chip_ph_q == PW'(CHIPS_PER_BIT - 1);
  assign bit_last   = bit_ph_q  == BW'(BITS_PER_BYTE - 1);
  assign byte_last  = byte_ix_q == YW'(BYTES_PER_FRAME - 1);
  assign frame_last = cnt_q     == CW'(FRAME_CHIPS - 1);

  assign bit_stb       = chip_en && chip_ph_q == '0;
  assign byte_stb      = bit_stb && bit_ph_q == '0;
  assign frame_stb     = byte_stb && byte_ix_q == '0;
  assign pre_byte_stb  = bit_stb && bit_ph_q == BW'(BITS_PER_BYTE - LEAD_BITS);
  assign pre_frame_stb = pre_byte_stb && byte_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      chip_ph_q <= '0;
      bit_ph_q  <= '0;
      byte_ix_q <= '0;
      slot_q    <= 1'b0;
    end else if (chip_en) begin
      cnt_q     <= frame_last ? '0 : cnt_q + 1'b1;
      chip_ph_q <= chip_last ? '0 : chip_ph_q + 1'b1;
      if (chip_last) begin
        bit_ph_q <= bit_last ? '0 : bit_ph_q + 1'b1;
        if (bit_last)
          byte_ix_q <= byte_last ? '0 : byte_ix_q + 1'b1;
      end
      if (pre_frame_stb)
        slot_q <= 1'b1;
      else if (frame_stb)
        slot_q <= 1'b0;
    end
  end

  assign chip_count = cnt_q;
  assign pre_slot   = slot_q;

endmodule

// File: rtl/subframe_timer_chk.sv
module subframe_timer_chk #(
  parameter int CHIPS_PER_BIT   = 8,
  parameter int BITS_PER_BYTE   = 8,
  parameter int BYTES_PER_FRAME = 45,
  parameter int LEAD_BITS       = 1,
  localparam int FRAME_CHIPS = CHIPS_PER_BIT * BITS_PER_BYTE * BYTES_PER_FRAME,
  localparam int BYTE_CHIPS  = CHIPS_PER_BIT * BITS_PER_BYTE,
  localparam int CW = $clog2(FRAME_CHIPS)
) (
  input logic          clk,
  input logic          rst,
  input logic          chip_en,
  input logic [CW-1:0] chip_count,
  input logic          bit_stb,
  input logic          byte_stb,
  input logic          frame_stb,
  input logic          pre_byte_stb,
  input logic          pre_frame_stb,
  input logic          pre_slot
);

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (chip_en && int'(chip_count) != FRAME_CHIPS - 1) |=> int'(chip_count) == int'($past(chip_count)) + 1);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (chip_en && int'(chip_count) == FRAME_CHIPS - 1) |=> chip_count == '0);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> $stable(chip_count));

  assert_bit_pos_R2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> int'(chip_count) % CHIPS_PER_BIT == 0);

  assert_byte_pos_R3: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> (bit_stb && int'(chip_count) % BYTE_CHIPS == 0));

  assert_frame_pos_R4: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> (byte_stb && chip_count == '0));

  assert_pre_byte_pos_R5: assert property (@(posedge clk) disable iff (rst)
    pre_byte_stb |-> int'(chip_count) % BYTE_CHIPS == BYTE_CHIPS - LEAD_BITS * CHIPS_PER_BIT);

  assert_pre_frame_pos_R6: assert property (@(posedge clk) disable iff (rst)
    pre_frame_stb |-> (pre_byte_stb && int'(chip_count) == FRAME_CHIPS - LEAD_BITS * CHIPS_PER_BIT));

  assert_slot_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pre_slot) |-> $past(pre_frame_stb));

  assert_slot_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pre_slot) |-> $past(frame_stb));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !chip_en |-> !(bit_stb || byte_stb || frame_stb || pre_byte_stb || pre_frame_stb));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (chip_count == '0 && !pre_slot));

endmodule

bind subframe_timer subframe_timer_chk #(
  .CHIPS_PER_BIT(CHIPS_PER_BIT), .BITS_PER_BYTE(BITS_PER_BYTE),
  .BYTES_PER_FRAME(BYTES_PER_FRAME), .LEAD_BITS(LEAD_BITS)
) chk_i (
  .clk(clk), .rst(rst), .chip_en(chip_en), .chip_count(chip_count),
  .bit_stb(bit_stb), .byte_stb(byte_stb), .frame_stb(frame_stb),
  .pre_byte_stb(pre_byte_stb), .pre_frame_stb(pre_frame_stb), .pre_slot(pre_slot)
);

// File: tb/subframe_timer_tb.sv
module subframe_timer_tb_top;

  localparam int FRAME = 2880;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0;
  logic tx_mode = 1'b0;
  logic [11:0] chip_count;
  logic bit_stb, byte_stb, frame_stb, pre_byte_stb, pre_frame_stb, pre_slot;

  always #4 clk = ~clk;

  subframe_timer dut_i (
    .clk(clk), .rst(rst), .chip_en(chip_en), .tx_mode(tx_mode),
    .chip_count(chip_count), .bit_stb(bit_stb), .byte_stb(byte_stb),
    .frame_stb(frame_stb), .pre_byte_stb(pre_byte_stb),
    .pre_frame_stb(pre_frame_stb), .pre_slot(pre_slot)
  );

  typedef struct {
    int cnt;
    bit b, y, f, pb, pf, ps, en, r, mtog;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;
  bit ref_ps = 1'b0;
  bit last_mode = 1'b0;
  bit done = 1'b0;
  int bytes_seen = 0;
  bit frame_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at time %0t", tag, act, expv, $time);
    end
  endtask

  task automatic drive(input bit en, input bit mode, input bit r);
    exp_t e;
    @(negedge clk);
    chip_en = en;
    tx_mode = mode;
    rst = r;
    e.cnt  = ref_cnt;
    e.en   = en;
    e.r    = r;
    e.mtog = (mode != last_mode);
    e.b    = en && (ref_cnt % 8 == 0);
    e.y    = en && (ref_cnt % 64 == 0);
    e.f    = en && (ref_cnt == 0);
    e.pb   = en && (ref_cnt % 64 == 56);
    e.pf   = en && (ref_cnt == 2872);
    e.ps   = ref_ps;
    q.push_back(e);
    -> chk_ev;
    last_mode = mode;
    if (r) begin
      ref_cnt = 0;
      ref_ps = 1'b0;
    end else if (en) begin
      if (e.pf) ref_ps = 1'b1;
      else if (e.f) ref_ps = 1'b0;
      ref_cnt = (ref_cnt == FRAME - 1) ? 0 : ref_cnt + 1;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(chk_ev);
      #1;
      e = q.pop_front();
      chk(int'(chip_count) == e.cnt, e.r ? "R10 count" : "R1 count", int'(chip_count), e.cnt);
      chk(pre_slot == e.ps, e.r ? "R10 pre_slot" : "R7 pre_slot", pre_slot, e.ps);
      chk(bit_stb == e.b, e.en ? "R2 bit" : "R8 bit", bit_stb, e.b);
      chk(byte_stb == e.y, e.en ? "R3 byte" : "R8 byte", byte_stb, e.y);
      chk(frame_stb == e.f, e.en ? "R4 frame" : "R8 frame", frame_stb, e.f);
      chk(pre_byte_stb == e.pb, e.en ? "R5 pre_byte" : "R8 pre_byte", pre_byte_stb, e.pb);
      chk(pre_frame_stb == e.pf, e.en ? "R6 pre_frame" : "R8 pre_frame", pre_frame_stb, e.pf);
      if (e.mtog)
        chk(int'(chip_count) == e.cnt, "R9 count across mode change", int'(chip_count), e.cnt);
      if (e.r) begin
        bytes_seen = 0;
        frame_seen = 1'b0;
      end else if (frame_stb) begin
        if (frame_seen)
          chk(bytes_seen == 45, "R3 bytes per subframe", bytes_seen, 45);
        frame_seen = 1'b1;
        bytes_seen = 1;
      end else if (byte_stb) begin
        bytes_seen++;
      end
    end
  end

  initial begin : stimulus
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) drive(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 2 * FRAME + 100; i++)
      drive(1'b1, (i / 500) % 2 == 1, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0], lfsr[5] & lfsr[9], 1'b0);
    end
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3000; i++)
      drive(1'b1, i % 7 == 0, 1'b0);
    for (int i = 0; i < 20; i++)
      drive(1'b0, i % 2 == 0, 1'b0);
    @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule